// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port on the slave side of the link. The far end supplies the shift clock on an external pin. The block brings that clock into the system clock domain through a synchroniser and an edge detector. On every active edge of the external clock it drives one data bit onto its serial output, least significant bit first. A frame is 8 data bits, or 9 bits when the ninth-bit option is on.

A host writes words through a one-cycle write strobe. If nothing is shifting, the word goes straight into the shift register. If the shift register is busy, the word waits in a one-word holding register. The ready flag tracks that holding register. An interrupt output follows the ready flag when it is enabled. A pending word is handed to the shift register on the external clock edge that closes the current frame, so frames can follow each other without a gap.

The transmitter runs only when every mode bit is in its slave-transmit setting. Any other setting flushes both registers, sets the ready flag and returns the line to its idle level.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when `cfg_sync_mode`, `cfg_port_en` and `cfg_tx_en` are 1 and `cfg_clk_master`, `cfg_rx_single` and `cfg_rx_cont` are 0. While it is inactive, writes are ignored, `sdo` stays at its idle level 1, and `tx_ready` and `tsr_empty` read 1.
- R2: A write made while nothing is shifting and the holding register is empty goes directly into the shift register. On the next cycle `tx_ready` is still 1 and `tsr_empty` is 0.
- R3: The active edge of `ext_sck` is the rising edge when `cfg_clk_pol`=0 and the falling edge when `cfg_clk_pol`=1. Each active edge drives the next frame bit on `sdo`, bit 0 first. `sdo` updates within 3 system clock cycles of the edge and holds its value between edges.
- R4: A write made while a frame is shifting and the holding register is empty is stored in the holding register. `tx_ready` is then 0 until that word moves into the shift register.
- R5: After the last bit of a frame has been driven, the next active edge ends the frame. If a word is pending, that same edge drives the pending word's bit 0 and `tx_ready` returns to 1. If no word is pending, `sdo` returns to 1 and `tsr_empty` returns to 1.
- R6: When `cfg_nine_bit`=1 at the time of the write, the frame is 9 bits long and bit 8 is the value of `ninth_bit_in` sampled with the write. When `cfg_nine_bit`=0, the frame is 8 bits long.
- R7: `tx_irq` is 1 exactly when `cfg_irq_en` is 1 and `tx_ready` is 1.
- R8: A write made while `tx_ready` is 0 is dropped, and the pending word is left unchanged.
- R9: Making the transmitter inactive in the middle of a frame aborts it. Within two cycles `sdo` is 1, both registers are empty and `tx_ready` is 1. A word that was pending is never sent.
- R10: `tsr_empty` is 1 exactly when no frame is shifting and no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_mode | input | 1 | Synchronous mode select |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_clk_master | input | 1 | Clock source select; must be 0 (external clock) |
| cfg_rx_single | input | 1 | Single receive enable; blocks transmission |
| cfg_rx_cont | input | 1 | Continuous receive enable; blocks transmission |
| cfg_nine_bit | input | 1 | 9-bit frame select |
| cfg_clk_pol | input | 1 | Clock polarity: 0 = idle low, 1 = idle high |
| cfg_irq_en | input | 1 | Transmit interrupt enable |
| ninth_bit_in | input | 1 | Ninth data bit, sampled with each write |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write data |
| ext_sck | input | 1 | External shift clock (asynchronous) |
| tx_ready | output | 1 | Holding register can accept a word |
| tx_irq | output | 1 | Transmit interrupt request |
| tsr_empty | output | 1 | Nothing shifting and nothing pending |
| sdo | output | 1 | Serial data output |

## Verification
The hardest state to reach from the ports is a second write arriving while a frame is mid-shift, with a third write then landing on the full holding register. The handover of the pending word must also fall on the very edge that closes the first frame. The stimulus gets there by issuing writes on consecutive cycles before any external clock edge, so the first word is already shifting. It then steps the external clock one edge at a time and checks `sdo`, `tx_ready` and `tx_irq` after each edge, so the handover edge is observed on its own. The same pending state is then aborted by dropping transmit enable, to show that the queued word is discarded.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam logic IDLE_LEVEL = 1'b1;

  // number of bits in one frame
  function automatic int unsigned frame_bits(input logic nine, input int unsigned dw);
    return nine ? dw + 1 : dw;
  endfunction
endpackage

// File: rtl/sstx_edge_detect.sv
module sstx_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic sck_async,
  output logic act_edge
);
  logic [STAGES-1:0] pipe;
  logic              norm;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= 1'b0;
          else     pipe[0] <= sck_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= 1'b0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  // normalised level: 1 means the active phase
  assign norm = pipe[STAGES-1] ^ pol;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= norm;
  end

  assign act_edge = norm & ~prev_q;

  // R3: an edge pulse never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    act_edge |=> !act_edge);
endmodule

// File: rtl/sstx_holding.sv
module sstx_holding #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned W = DATA_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         accept,
  input  logic [W-1:0] in_word,
  input  logic         in_nine,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] word,
  output logic         nine
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid <= 1'b0;
      word  <= '0;
      nine  <= 1'b0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (accept && !valid) begin
      valid <= 1'b1;
      word  <= in_word;
      nine  <= in_nine;
    end
  end

  // R8: a pending word stays put until it is taken or flushed
  a_r8_keep_pending: assert property (@(posedge clk) disable iff (rst)
    (valid && !take && !flush) |=> (valid && $stable(word) && $stable(nine)));
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned W  = DATA_W + 1,
  localparam int unsigned CW = $clog2(DATA_W + 2)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         load_nine,
  output logic         busy,
  output logic         at_end,
  output logic         sdo
);
  import sstx_pkg::*;

  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] load_len;

  assign load_len = CW'(frame_bits(load_nine, DATA_W));
  assign at_end   = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy   <= 1'b0;
      data_q <= '0;
      cnt_q  <= '0;
      len_q  <= CW'(DATA_W);
      sdo    <= IDLE_LEVEL;
    end else if (adv && busy) begin
      if (!at_end) begin
        sdo    <= data_q[0];
        data_q <= data_q >> 1;
        cnt_q  <= cnt_q + 1'b1;
      end else if (load) begin
        // back-to-back: next frame's first bit on the closing edge
        sdo    <= load_word[0];
        data_q <= load_word >> 1;
        cnt_q  <= CW'(1);
        len_q  <= load_len;
      end else begin
        busy <= 1'b0;
        sdo  <= IDLE_LEVEL;
      end
    end else if (load && !busy) begin
      busy   <= 1'b1;
      data_q <= load_word;
      cnt_q  <= '0;
      len_q  <= load_len;
    end
  end

  // R6: bit count never passes the frame length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= len_q));
  // R3: line holds between edges
  a_r3_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (!flush && !adv) |=> $stable(sdo));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sync_mode,
  input  logic              cfg_port_en,
  input  logic              cfg_tx_en,
  input  logic              cfg_clk_master,
  input  logic              cfg_rx_single,
  input  logic              cfg_rx_cont,
  input  logic              cfg_nine_bit,
  input  logic              cfg_clk_pol,
  input  logic              cfg_irq_en,
  input  logic              ninth_bit_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_sck,
  output logic              tx_ready,
  output logic              tx_irq,
  output logic              tsr_empty,
  output logic              sdo
);
  import sstx_pkg::*;

  logic         active;
  logic         act_edge;
  logic         sh_busy, sh_at_end;
  logic         hold_valid, hold_nine;
  logic [W-1:0] hold_word;
  logic [W-1:0] wr_word;
  logic         direct_ld, take, accept, sh_load;
  logic [W-1:0] ld_word;
  logic         ld_nine;

  assign active = cfg_sync_mode & cfg_port_en & cfg_tx_en & ~cfg_clk_master
                & ~cfg_rx_single & ~cfg_rx_cont;

  sstx_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pol(cfg_clk_pol), .sck_async(ext_sck), .act_edge(act_edge)
  );

  assign wr_word   = {ninth_bit_in & cfg_nine_bit, wr_data};
  assign direct_ld = active & wr_en & ~sh_busy & ~hold_valid;
  assign take      = active & hold_valid & (~sh_busy | (act_edge & sh_at_end));
  assign accept    = active & wr_en & ~hold_valid & sh_busy;
  assign sh_load   = direct_ld | take;
  assign ld_word   = take ? hold_word : wr_word;
  assign ld_nine   = take ? hold_nine : cfg_nine_bit;

  sstx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .flush(~active), .accept(accept),
    .in_word(wr_word), .in_nine(cfg_nine_bit), .take(take),
    .valid(hold_valid), .word(hold_word), .nine(hold_nine)
  );

  sstx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .flush(~active), .adv(act_edge), .load(sh_load),
    .load_word(ld_word), .load_nine(ld_nine),
    .busy(sh_busy), .at_end(sh_at_end), .sdo(sdo)
  );

  assign tx_ready  = ~hold_valid;
  assign tsr_empty = ~sh_busy & ~hold_valid;
  assign tx_irq    = cfg_irq_en & tx_ready;

  // R9: inactive state drains to idle
  a_r9_flush_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> (tx_ready && tsr_empty && sdo == IDLE_LEVEL));
  // R4: write into a busy shifter clears ready
  a_r4_pending_clears_ready: assert property (@(posedge clk) disable iff (rst)
    (active && wr_en && sh_busy && hold_valid == 1'b0) |=> !tx_ready);
  // R2: direct load starts shifting with ready still set
  a_r2_direct_load: assert property (@(posedge clk) disable iff (rst)
    direct_ld |=> (tx_ready && !tsr_empty));
endmodule

// File: tb/tb_sync_slave_tx.sv
module tb_sync_slave_tx;
  localparam int unsigned DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_sync_mode = 1'b0, cfg_port_en = 1'b0, cfg_tx_en = 1'b0;
  logic cfg_clk_master = 1'b0, cfg_rx_single = 1'b0, cfg_rx_cont = 1'b0;
  logic cfg_nine_bit = 1'b0, cfg_clk_pol = 1'b0, cfg_irq_en = 1'b0;
  logic ninth_bit_in = 1'b0, wr_en = 1'b0, ext_sck = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic tx_ready, tx_irq, tsr_empty, sdo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sync_slave_tx #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cfg_sync_mode(cfg_sync_mode), .cfg_port_en(cfg_port_en),
    .cfg_tx_en(cfg_tx_en), .cfg_clk_master(cfg_clk_master), .cfg_rx_single(cfg_rx_single),
    .cfg_rx_cont(cfg_rx_cont), .cfg_nine_bit(cfg_nine_bit), .cfg_clk_pol(cfg_clk_pol),
    .cfg_irq_en(cfg_irq_en), .ninth_bit_in(ninth_bit_in), .wr_en(wr_en), .wr_data(wr_data),
    .ext_sck(ext_sck), .tx_ready(tx_ready), .tx_irq(tx_irq), .tsr_empty(tsr_empty), .sdo(sdo)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic enable_all();
    @(negedge clk);
    cfg_sync_mode = 1; cfg_port_en = 1; cfg_tx_en = 1;
    cfg_clk_master = 0; cfg_rx_single = 0; cfg_rx_cont = 0;
  endtask

  task automatic write(input logic [DW-1:0] d, input logic n9);
    @(negedge clk);
    wr_en = 1; wr_data = d; ninth_bit_in = n9;
    @(negedge clk);
    wr_en = 0;
  endtask

  // one active edge, then sample away from the clock edge
  task automatic pulse();
    ext_sck = ~cfg_clk_pol;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic unpulse();
    ext_sck = cfg_clk_pol;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic n9, input string tag);
    int unsigned len;
    logic [DW:0] w;
    len = cfg_nine_bit ? DW + 1 : DW;
    w = {n9 & cfg_nine_bit, d};
    for (int k = 0; k < len; k++) begin
      pulse();
      chk(tag, sdo, w[k]);
      unpulse();
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ready", tx_ready, 1);
    chk("R1 reset tsr_empty", tsr_empty, 1);
    chk("R1 reset sdo", sdo, 1);
    chk("R7 irq off", tx_irq, 0);

    // R1: each blocking condition on its own
    for (int b = 0; b < 6; b++) begin
      enable_all();
      case (b)
        0: cfg_sync_mode = 0;
        1: cfg_port_en = 0;
        2: cfg_tx_en = 0;
        3: cfg_clk_master = 1;
        4: cfg_rx_single = 1;
        default: cfg_rx_cont = 1;
      endcase
      repeat (2) @(negedge clk);
      write(8'h00, 0);
      chk("R1 blocked tsr_empty", tsr_empty, 1);
      chk("R1 blocked ready", tx_ready, 1);
      pulse();
      chk("R1 blocked sdo", sdo, 1);
      unpulse();
    end

    // sweep: polarity x frame length
    for (int cfg = 0; cfg < 4; cfg++) begin
      @(negedge clk);
      cfg_tx_en = 0;
      cfg_clk_pol = cfg[0];
      cfg_nine_bit = cfg[1];
      ext_sck = cfg_clk_pol;
      repeat (6) @(negedge clk);
      enable_all();
      repeat (2) @(negedge clk);
      for (int i = 0; i < ((cfg == 0) ? 256 : 24); i++) begin
        logic [DW-1:0] d;
        logic n9;
        d  = (cfg == 0) ? DW'(i) : DW'(i * 37 + 5);
        n9 = i[0] ^ i[2];
        write(d, n9);
        chk("R2 ready after direct", tx_ready, 1);
        chk("R2 busy after direct", tsr_empty, 0);
        send_frame(d, n9, cfg[1] ? "R6 nine-bit frame" : "R3 frame bit");
        pulse();
        chk("R5 idle after frame", sdo, 1);
        chk("R10 empty after frame", tsr_empty, 1);
        unpulse();
      end
    end

    // back-to-back writes, third write dropped
    @(negedge clk);
    cfg_tx_en = 0; cfg_clk_pol = 0; cfg_nine_bit = 0; ext_sck = 0; cfg_irq_en = 1;
    repeat (6) @(negedge clk);
    enable_all();
    repeat (2) @(negedge clk);
    chk("R7 irq when ready", tx_irq, 1);
    @(negedge clk);
    wr_en = 1; wr_data = 8'h96;
    @(negedge clk);
    wr_data = 8'h3B;
    @(negedge clk);
    wr_en = 0;
    chk("R4 ready low pending", tx_ready, 0);
    chk("R7 irq low pending", tx_irq, 0);
    chk("R10 not empty pending", tsr_empty, 0);
    write(8'hFF, 0);
    send_frame(8'h96, 0, "R4 first frame");
    chk("R4 still pending", tx_ready, 0);
    pulse();
    chk("R5 handover bit0", sdo, 1);
    chk("R5 ready after handover", tx_ready, 1);
    chk("R7 irq after handover", tx_irq, 1);
    unpulse();
    begin
      logic [DW-1:0] b;
      b = 8'h3B;
      for (int k = 1; k < DW; k++) begin
        pulse();
        chk("R8 second frame kept", sdo, b[k]);
        unpulse();
      end
    end
    pulse();
    chk("R8 dropped word not sent", sdo, 1);
    chk("R10 empty at end", tsr_empty, 1);
    unpulse();

    // abort mid-frame with a pending word
    write(8'h00, 0);
    write(8'h00, 0);
    for (int k = 0; k < 3; k++) begin pulse(); unpulse(); end
    chk("R9 pending before abort", tx_ready, 0);
    @(negedge clk);
    cfg_tx_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 abort sdo", sdo, 1);
    chk("R9 abort ready", tx_ready, 1);
    chk("R9 abort empty", tsr_empty, 1);
    enable_all();
    repeat (2) @(negedge clk);
    for (int k = 0; k < DW + 2; k++) begin
      pulse();
      chk("R9 nothing sent after abort", sdo, 1);
      unpulse();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule